// File: doc/BRIEF.md
# GPIO Bank Interrupt Detector

This block watches a bank of 32 already-synchronised GPIO input lines and turns selected events on them into a single interrupt request. Each line chooses its own trigger condition: rising edge, falling edge, either edge, high level or low level. The choice is made through three per-line select bits held in three separate registers. When a line's condition is met, its bit in a sticky status register is set. Software clears status bits by writing ones to them.

A per-line enable register gates which status bits reach the combined interrupt output. Status still records events on lines that are not enabled. Software can therefore poll for events without taking interrupts, and it can enable a line later without missing an event that happened earlier.

The register port is a simple single-cycle write strobe with a byte-offset address and a combinational read-data path. Edges are found by comparing each line with its value on the previous clock cycle.

Top module: `bank_event_irq`

## Requirements
- R1: After reset the enable register and the status register read 0. The type0 and type1 registers read all ones, the type2 register reads 0, and irq_o is 0.
- R2: Register byte offsets are: enable 0x00, type0 0x04, type1 0x08, type2 0x0C, status 0x10. The enable and type registers read back the last value written. Any other offset reads 0.
- R3: A line with type1=1 and type0=1 sets its status bit on every cycle in which the line is high.
- R4: A line with type1=1 and type0=0 sets its status bit on every cycle in which the line is low.
- R5: A line with type1=0, type2=0 and type0=1 sets its status bit once, when it goes from 0 to 1 between consecutive cycles. Holding the line high or lowering it adds no further event.
- R6: A line with type1=0, type2=0 and type0=0 sets its status bit only when it goes from 1 to 0.
- R7: A line with type1=0 and type2=1 sets its status bit on both a 0-to-1 and a 1-to-0 change, whatever its type0 bit.
- R8: Writing to the status offset clears each status bit written as 1. Bits written as 0 are unchanged.
- R9: A status bit is set by its event whether or not the line's enable bit is set, and stays set until cleared.
- R10: irq_o is high exactly when some line has both its status bit and its enable bit set. It follows enable writes in the same cycle that the register changes.
- R11: If an event and a clearing write hit the same bit in the same cycle, the bit stays set. A level condition that still holds therefore re-asserts status straight after a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| line_i | input | 32 | Sampled GPIO input values, one bit per line |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Register byte offset |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data for addr_i, combinational |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach is a clear that collides with a live event. The bench has to issue the status write while a level condition is still true, or while the edge that triggered the event is still in its detection cycle. It also has to tell that case apart from a clear after an edge that is held, where no new event may follow. To get there, the bench changes a line on one falling clock edge, writes the status register on the next cycle while the line is held, and reads status back before the line moves again. Mode changes are ordered so that the bench can exercise every trigger type without a transient level-low setting raising unwanted status bits.

// File: rtl/bank_event_irq_pkg.sv
package bank_event_irq_pkg;
  localparam int unsigned ADDR_W = 5;

  localparam logic [ADDR_W-1:0] OFS_ENABLE = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_TYPE0  = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_TYPE1  = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_TYPE2  = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_STATUS = 5'h10;
endpackage

// File: rtl/bank_event_cfg.sv
module bank_event_cfg
  import bank_event_irq_pkg::*;
#(
  parameter int unsigned NUM_LINES = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [NUM_LINES-1:0] wdata_i,
  output logic [NUM_LINES-1:0] enable_o,
  output logic [NUM_LINES-1:0] type0_o,
  output logic [NUM_LINES-1:0] type1_o,
  output logic [NUM_LINES-1:0] type2_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enable_o <= '0;
      type0_o  <= '1;
      type1_o  <= '1;
      type2_o  <= '0;
    end else if (wr_en_i) begin
      unique case (addr_i)
        OFS_ENABLE: enable_o <= wdata_i;
        OFS_TYPE0:  type0_o  <= wdata_i;
        OFS_TYPE1:  type1_o  <= wdata_i;
        OFS_TYPE2:  type2_o  <= wdata_i;
        default: ;
      endcase
    end
  end

  // R2: a write to the type1 offset only moves type1
  p_type1_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFS_TYPE1) |=> (type1_o == $past(wdata_i)));
endmodule

// File: rtl/bank_event_det.sv
module bank_event_det #(
  parameter int unsigned NUM_LINES = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] line_i,
  input  logic [NUM_LINES-1:0] type0_i,
  input  logic [NUM_LINES-1:0] type1_i,
  input  logic [NUM_LINES-1:0] type2_i,
  output logic [NUM_LINES-1:0] event_o
);
  logic [NUM_LINES-1:0] prev_q;
  logic                 armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      prev_q  <= line_i;
      armed_q <= 1'b1;
    end
  end

  for (genvar gi = 0; gi < NUM_LINES; gi++) begin : g_line
    logic rise_w, fall_w, edge_ev_w, level_ev_w;
    assign rise_w     = line_i[gi] & ~prev_q[gi];
    assign fall_w     = ~line_i[gi] & prev_q[gi];
    // type2 overrides the rise/fall choice in edge mode
    assign edge_ev_w  = type2_i[gi] ? (rise_w | fall_w)
                                    : (type0_i[gi] ? rise_w : fall_w);
    assign level_ev_w = type0_i[gi] ? line_i[gi] : ~line_i[gi];
    assign event_o[gi] = type1_i[gi] ? level_ev_w : edge_ev_w;
  end

  // R5: edge-mode events need a change against the previous cycle
  p_edge_needs_change_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> ((event_o & ~type1_i & ~(line_i ^ $past(line_i))) == '0));
  // R3: a held high level in level-high mode always yields an event
  p_level_high_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((type1_i & type0_i & line_i & ~event_o) == '0));
  // R4: a held low level in level-low mode always yields an event
  p_level_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((type1_i & ~type0_i & ~line_i & ~event_o) == '0));
endmodule

// File: rtl/bank_event_status.sv
module bank_event_status #(
  parameter int unsigned NUM_LINES = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] event_i,
  input  logic [NUM_LINES-1:0] clr_i,
  input  logic [NUM_LINES-1:0] enable_i,
  output logic [NUM_LINES-1:0] status_o,
  output logic                 irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_o <= '0;
    else         status_o <= (status_o & ~clr_i) | event_i; // set wins
  end

  assign irq_o = |(status_o & enable_i);

  // R9: every event is captured, enabled or not
  p_event_latched_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (event_i != '0) |=> ((status_o & $past(event_i)) == $past(event_i)));
  // R11: uncleared bits never drop
  p_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(status_o & ~clr_i) & ~status_o) == '0));
  // R8: cleared bits without a new event go low
  p_w1c_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i != '0) |=> ((status_o & $past(clr_i & ~event_i)) == '0));
  // R10: no status, no interrupt
  p_irq_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == '0) |-> !irq_o);
endmodule

// File: rtl/bank_event_irq.sv
module bank_event_irq
  import bank_event_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [31:0]       line_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o
);
  localparam int unsigned NUM_LINES = 32;

  logic [NUM_LINES-1:0] enable_w, type0_w, type1_w, type2_w;
  logic [NUM_LINES-1:0] event_w, status_w, clr_w;

  bank_event_cfg #(.NUM_LINES(NUM_LINES)) u_cfg (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .enable_o(enable_w), .type0_o(type0_w), .type1_o(type1_w), .type2_o(type2_w)
  );

  bank_event_det #(.NUM_LINES(NUM_LINES)) u_det (
    .clk_i, .rst_ni, .line_i,
    .type0_i(type0_w), .type1_i(type1_w), .type2_i(type2_w),
    .event_o(event_w)
  );

  assign clr_w = (wr_en_i && addr_i == OFS_STATUS) ? wdata_i : '0;

  bank_event_status #(.NUM_LINES(NUM_LINES)) u_status (
    .clk_i, .rst_ni, .event_i(event_w), .clr_i(clr_w),
    .enable_i(enable_w), .status_o(status_w), .irq_o
  );

  always_comb begin
    unique case (addr_i)
      OFS_ENABLE: rdata_o = enable_w;
      OFS_TYPE0:  rdata_o = type0_w;
      OFS_TYPE1:  rdata_o = type1_w;
      OFS_TYPE2:  rdata_o = type2_w;
      OFS_STATUS: rdata_o = status_w;
      default:    rdata_o = '0;
    endcase
  end

  // R1: state right after reset release
  p_reset_state_r1: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (enable_w == '0 && type2_w == '0));
endmodule

// File: tb/bank_event_irq_test.sv
module bank_event_irq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] line = '0;
  logic        we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int fails  = 0;

  localparam logic [4:0] A_EN = 5'h00, A_T0 = 5'h04, A_T1 = 5'h08,
                         A_T2 = 5'h0C, A_ST = 5'h10;

  always #2 clk = ~clk;

  bank_event_irq uut (
    .clk_i(clk), .rst_ni(rst_n), .line_i(line), .wr_en_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    addr = a;
    #0.5;
    d = rdata;
  endtask

  task automatic set_lines(input logic [31:0] v);
    @(negedge clk);
    line = v;
    @(negedge clk);
  endtask

  task automatic chk_st(input string tag, input logic [31:0] exp);
    logic [31:0] d;
    rd(A_ST, d);
    chk(tag, d, exp);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(A_EN, d); chk("R1 enable", d, 32'h0);
    rd(A_T0, d); chk("R1 type0", d, 32'hFFFF_FFFF);
    rd(A_T1, d); chk("R1 type1", d, 32'hFFFF_FFFF);
    rd(A_T2, d); chk("R1 type2", d, 32'h0);
    chk_st("R1 status", 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    wr(A_T2, 32'h1234_5678);
    rd(A_T2, d); chk("R2 type2 readback", d, 32'h1234_5678);
    wr(A_T2, 32'h0);
    wr(A_EN, 32'hA5A5_0000);
    rd(A_EN, d); chk("R2 enable readback", d, 32'hA5A5_0000);
    chk("R2 irq with empty status", {31'b0, irq}, 32'h0);
    wr(A_EN, 32'h0);
    rd(5'h14, d); chk("R2 unmapped read", d, 32'h0);
  endtask

  task automatic t_level_high;
    set_lines(32'h8);
    chk_st("R3 level high sets", 32'h8);
    chk("R9 irq gated while disabled", {31'b0, irq}, 32'h0);
    wr(A_EN, 32'h8);
    chk("R10 irq after enable", {31'b0, irq}, 32'h1);
    wr(A_ST, 32'h8);
    chk_st("R11 clear loses to held level", 32'h8);
    set_lines(32'h0);
    chk_st("R9 sticky after level drops", 32'h8);
    wr(A_ST, 32'h0);
    chk_st("R8 zero write keeps bit", 32'h8);
    wr(A_ST, 32'h8);
    chk_st("R8 one write clears", 32'h0);
    chk("R10 irq drops after clear", {31'b0, irq}, 32'h0);
    wr(A_EN, 32'h0);
  endtask

  task automatic t_edges;
    // line5 rising, line6 falling, line7 both
    wr(A_T1, 32'hFFFF_FF1F);
    wr(A_T0, 32'hFFFF_FFBF);
    wr(A_T2, 32'h0000_0080);
    chk_st("R5 no event on mode change", 32'h0);
    set_lines(32'h20);
    chk_st("R5 rising sets", 32'h20);
    wr(A_ST, 32'h20);
    chk_st("R5 held high no repeat", 32'h0);
    set_lines(32'h0);
    chk_st("R5 falling ignored", 32'h0);
    set_lines(32'h40);
    chk_st("R6 rising ignored", 32'h0);
    set_lines(32'h0);
    chk_st("R6 falling sets", 32'h40);
    wr(A_ST, 32'h40);
    set_lines(32'h80);
    chk_st("R7 both: rise", 32'h80);
    wr(A_ST, 32'h80);
    chk_st("R7 cleared", 32'h0);
    set_lines(32'h0);
    chk_st("R7 both: fall", 32'h80);
    wr(A_ST, 32'h80);
  endtask

  task automatic t_level_low;
    wr(A_T0, 32'hFFFF_FDBF);
    @(negedge clk);
    chk_st("R4 level low sets", 32'h200);
    set_lines(32'h200);
    wr(A_ST, 32'h200);
    chk_st("R4 high line no event", 32'h0);
    set_lines(32'h0);
    chk_st("R4 low again sets", 32'h200);
    wr(A_T0, 32'hFFFF_FFBF);
    wr(A_ST, 32'h200);
    chk_st("R4 cleared after restore", 32'h0);
  endtask

  task automatic t_boundary;
    wr(A_EN, 32'h8000_0001);
    set_lines(32'h8000_0001);
    chk_st("R3 lines 0 and 31", 32'h8000_0001);
    chk("R10 irq outer lines", {31'b0, irq}, 32'h1);
    wr(A_EN, 32'h0);
    chk("R10 irq off with status kept", {31'b0, irq}, 32'h0);
    wr(A_EN, 32'h8000_0000);
    chk("R10 irq bit31 only", {31'b0, irq}, 32'h1);
    set_lines(32'h0);
    wr(A_ST, 32'h0000_0001);
    chk_st("R8 partial clear", 32'h8000_0000);
    chk("R10 irq still from bit31", {31'b0, irq}, 32'h1);
    wr(A_ST, 32'h8000_0000);
    chk("R10 irq after full clear", {31'b0, irq}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_level_high();
    t_edges();
    t_level_low();
    t_boundary();
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule